// File: doc/BRIEF.md
# Cross-Domain Match Timer

This block keeps a free-running up-counter in a slow tick clock domain and exposes it to software through a small word-wide register port clocked by a faster bus clock. The counter can be started and stopped, loaded with a new value, and compared against up to four match values. When the count equals a match value on a tick while counting, a sticky flag is raised. Flag 0, when enabled, drives the interrupt output.

The counter domain is never sampled directly from the bus side. Software obtains the count by requesting a snapshot through the control register and then polling a busy flag until the captured value has been moved across. Loads of the counter and updates of the match values cross the same way, each with its own busy flag. While a transfer is outstanding, a further request of the same kind is dropped. Software is expected to poll before issuing another.

Top module: `tmx_timer`

## Requirements
- R1: After reset, every match register reads 0xFFFFFFFF. Count, status, interrupt enable, control and access status read 0, and `irq` is low.
- R2: Register byte offsets: match i at 4*i (i = 0..3), count 0x10, status 0x14, interrupt enable 0x1C, control 0x20, access status 0x24. Other offsets read 0. A read request is answered with `rsp_valid` high and the data in the bus cycle after it is taken.
- R3: Control bit 0 is the run enable. While it is set, the counter advances by one on each tick. While it is clear, the counter holds.
- R4: Writing control with bit 1 set requests a snapshot of the live count. Access-status bit 5 reads 1 from the next bus cycle until the snapshot has reached the count register. A later read of offset 0x10 returns the snapshot, and that register does not change otherwise.
- R5: A write to offset 0x10 loads the counter. Access-status bit 4 reads 1 from the next bus cycle until the load has been acknowledged.
- R6: A write to any match register starts a transfer to the counter domain. Access-status bit 0 reads 1 while it is outstanding. A match write issued while bit 0 is set is dropped, and the register keeps its earlier value.
- R7: The counter wraps from 0xFFFFFFFF to 0.
- R8: When the count equals match i on a tick while counting, status bit i becomes 1.
- R9: Status bits are cleared by writing 1 to them. Bits written 0 are unchanged, and writing 0xF clears all four.
- R10: When a status bit is set in the same bus cycle that software writes 1 to clear it, the bit ends up set.
- R11: `irq` is status bit 0 AND interrupt-enable bit 0. Status bits 1 to 3 never drive it.
- R12: A counter load issued while access-status bit 4 is set is dropped, and the first load stays in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register port clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| tick_clk | input | 1 | Counter tick clock |
| tick_rst_n | input | 1 | Active-low asynchronous reset, tick domain |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Match-0 interrupt |

## Verification
The collision that matters is a match event reaching the bus domain in the very cycle that software writes 1 to clear the same status bit. The bench provokes it by writing the clear to status bit 0 on every bus cycle while the counter runs up to match 0. With set priority, `irq` is seen high for exactly one cycle before the next clear takes effect. If clear had priority, it would never be seen high. The busy bits are also exercised by issuing a second load or match write on the cycle right after the first, and the bench then checks that the first value survives.

// File: rtl/tmx_pkg.sv
package tmx_pkg;
   localparam int unsigned ADDR_W   = 6;
   localparam int unsigned BUS_W    = 32;
   localparam int unsigned MAX_MTCH = 4;

   localparam logic [ADDR_W-1:0] A_MATCH0 = 6'h00;
   localparam logic [ADDR_W-1:0] A_COUNT  = 6'h10;
   localparam logic [ADDR_W-1:0] A_STATUS = 6'h14;
   localparam logic [ADDR_W-1:0] A_IRQEN  = 6'h1C;
   localparam logic [ADDR_W-1:0] A_CTRL   = 6'h20;
   localparam logic [ADDR_W-1:0] A_ACCESS = 6'h24;

   localparam int unsigned ACC_MATCH = 0;
   localparam int unsigned ACC_LOAD  = 4;
   localparam int unsigned ACC_SNAP  = 5;
   localparam int unsigned CTL_RUN   = 0;
   localparam int unsigned CTL_SNAP  = 1;
endpackage

// File: rtl/tmx_sync.sv
module tmx_sync #(
   parameter int unsigned W           = 1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad
         $error("tmx_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [SYNC_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[SYNC_STAGES-1];
endmodule

// File: rtl/tmx_xfer.sv
module tmx_xfer #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic src_clk,
   input  logic src_rst_n,
   input  logic src_go,
   output logic src_busy,
   output logic src_done,
   input  logic dst_clk,
   input  logic dst_rst_n,
   output logic dst_pulse
);
   logic req_tgl, req_s, seen, ack_s, ack_q;

   always_ff @(posedge src_clk or negedge src_rst_n) begin
      if (!src_rst_n) begin
         req_tgl <= 1'b0;
         ack_q   <= 1'b0;
      end else begin
         req_tgl <= req_tgl ^ src_go;
         ack_q   <= ack_s;
      end
   end

   tmx_sync #(.W(1), .SYNC_STAGES(SYNC_STAGES)) u_req_sync (
      .clk(dst_clk), .rst_n(dst_rst_n), .d(req_tgl), .q(req_s));

   always_ff @(posedge dst_clk or negedge dst_rst_n) begin
      if (!dst_rst_n) seen <= 1'b0;
      else            seen <= req_s;
   end

   assign dst_pulse = req_s ^ seen;

   tmx_sync #(.W(1), .SYNC_STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(src_clk), .rst_n(src_rst_n), .d(seen), .q(ack_s));

   assign src_busy = req_tgl ^ ack_s;
   assign src_done = ack_s ^ ack_q;
endmodule

// File: rtl/tmx_tick_core.sv
module tmx_tick_core #(
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned NUM_MATCH = 4,
   parameter int unsigned IDX_W     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 ld_go,
   input  logic [CNT_W-1:0]     ld_val,
   input  logic                 m_go,
   input  logic [IDX_W-1:0]     m_idx,
   input  logic [CNT_W-1:0]     m_val,
   input  logic                 snap_go,
   output logic [CNT_W-1:0]     snap_val,
   output logic [NUM_MATCH-1:0] hit_tgl
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         snap_val <= '0;
      end else begin
         if (ld_go)    cnt <= ld_val;
         else if (run) cnt <= cnt + 1'b1;
         if (snap_go)  snap_val <= cnt;
      end
   end

   for (genvar g = 0; g < NUM_MATCH; g++) begin : g_cmp
      logic [CNT_W-1:0] mv;
      logic             tg;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mv <= '1;
            tg <= 1'b0;
         end else begin
            if (m_go && (m_idx == IDX_W'(g))) mv <= m_val;
            if (run && (cnt == mv))           tg <= ~tg;
         end
      end
      assign hit_tgl[g] = tg;
   end
endmodule

// File: rtl/tmx_timer.sv
module tmx_timer
   import tmx_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned NUM_MATCH   = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              bus_clk,
   input  logic              bus_rst_n,
   input  logic              tick_clk,
   input  logic              tick_rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [5:0]        req_addr,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   output logic              irq
);
   localparam int unsigned IDX_W = (NUM_MATCH > 1) ? $clog2(NUM_MATCH) : 1;

   generate
      if (CNT_W < 1 || CNT_W > BUS_W) begin : g_bad_w
         $error("tmx_timer: CNT_W must be 1..32");
      end
      if (NUM_MATCH < 1 || NUM_MATCH > MAX_MTCH) begin : g_bad_m
         $error("tmx_timer: NUM_MATCH must be 1..4");
      end
   endgenerate

   // decode
   logic wr, rd, wr_match, wr_count, wr_ctrl, wr_status, wr_ien;
   assign wr        = req_valid && req_write;
   assign rd        = req_valid && !req_write;
   assign wr_match  = wr && (req_addr[5:4] == 2'b00) && (req_addr[1:0] == 2'b00)
                      && (32'(req_addr[3:2]) < NUM_MATCH);
   assign wr_count  = wr && (req_addr == A_COUNT);
   assign wr_ctrl   = wr && (req_addr == A_CTRL);
   assign wr_status = wr && (req_addr == A_STATUS);
   assign wr_ien    = wr && (req_addr == A_IRQEN);

   // bus-domain state
   logic [NUM_MATCH-1:0][CNT_W-1:0] match_sh;
   logic [CNT_W-1:0]     mval_q, cval_q, cnt_rd, snap_val;
   logic [IDX_W-1:0]     midx_q;
   logic [NUM_MATCH-1:0] status, hit_s, hit_q, hit_set, clr;
   logic                 ien_q, run_q;
   logic                 m_busy, m_done, m_pulse;
   logic                 c_busy, c_done, c_pulse;
   logic                 s_busy, s_done, s_pulse;
   logic                 m_go, c_go, s_go, run_t;
   logic [NUM_MATCH-1:0] hit_tgl;

   assign m_go    = wr_match && !m_busy;
   assign c_go    = wr_count && !c_busy;
   assign s_go    = wr_ctrl && req_wdata[CTL_SNAP] && !s_busy;
   assign hit_set = hit_s ^ hit_q;
   assign clr     = wr_status ? req_wdata[NUM_MATCH-1:0] : '0;

   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) begin
         match_sh <= '1;
         mval_q   <= '1;
         midx_q   <= '0;
         cval_q   <= '0;
         cnt_rd   <= '0;
         status   <= '0;
         hit_q    <= '0;
         ien_q    <= 1'b0;
         run_q    <= 1'b0;
      end else begin
         for (int i = 0; i < NUM_MATCH; i++) begin
            if (m_go && (32'(req_addr[3:2]) == i)) match_sh[i] <= req_wdata[CNT_W-1:0];
         end
         if (m_go) begin
            mval_q <= req_wdata[CNT_W-1:0];
            midx_q <= IDX_W'(req_addr[3:2]);
         end
         if (c_go)    cval_q <= req_wdata[CNT_W-1:0];
         if (s_done)  cnt_rd <= snap_val;
         if (wr_ctrl) run_q  <= req_wdata[CTL_RUN];
         if (wr_ien)  ien_q  <= req_wdata[0];
         hit_q  <= hit_s;
         status <= (status & ~clr) | hit_set;   // a new hit beats a clear
      end
   end

   // read port
   logic [31:0] rmux, acc;
   always_comb begin
      acc           = '0;
      acc[ACC_MATCH] = m_busy;
      acc[ACC_LOAD]  = c_busy;
      acc[ACC_SNAP]  = s_busy;
      rmux = '0;
      case (req_addr)
         A_COUNT:  rmux = 32'(cnt_rd);
         A_STATUS: rmux = 32'(status);
         A_IRQEN:  rmux = {31'b0, ien_q};
         A_CTRL:   rmux = {31'b0, run_q};
         A_ACCESS: rmux = acc;
         default: begin
            for (int i = 0; i < NUM_MATCH; i++) begin
               if (req_addr == A_MATCH0 + 6'(4 * i)) rmux = 32'(match_sh[i]);
            end
         end
      endcase
   end

   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd;
         rsp_rdata <= rd ? rmux : '0;
      end
   end

   assign irq = status[0] & ien_q;

   // crossings
   tmx_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_mx (
      .src_clk(bus_clk), .src_rst_n(bus_rst_n), .src_go(m_go), .src_busy(m_busy),
      .src_done(m_done), .dst_clk(tick_clk), .dst_rst_n(tick_rst_n), .dst_pulse(m_pulse));
   tmx_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_cx (
      .src_clk(bus_clk), .src_rst_n(bus_rst_n), .src_go(c_go), .src_busy(c_busy),
      .src_done(c_done), .dst_clk(tick_clk), .dst_rst_n(tick_rst_n), .dst_pulse(c_pulse));
   tmx_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_sx (
      .src_clk(bus_clk), .src_rst_n(bus_rst_n), .src_go(s_go), .src_busy(s_busy),
      .src_done(s_done), .dst_clk(tick_clk), .dst_rst_n(tick_rst_n), .dst_pulse(s_pulse));

   tmx_sync #(.W(1), .SYNC_STAGES(SYNC_STAGES)) u_run_sync (
      .clk(tick_clk), .rst_n(tick_rst_n), .d(run_q), .q(run_t));
   tmx_sync #(.W(NUM_MATCH), .SYNC_STAGES(SYNC_STAGES)) u_hit_sync (
      .clk(bus_clk), .rst_n(bus_rst_n), .d(hit_tgl), .q(hit_s));

   tmx_tick_core #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH), .IDX_W(IDX_W)) u_core (
      .clk(tick_clk), .rst_n(tick_rst_n), .run(run_t),
      .ld_go(c_pulse), .ld_val(cval_q),
      .m_go(m_pulse), .m_idx(midx_q), .m_val(mval_q),
      .snap_go(s_pulse), .snap_val(snap_val), .hit_tgl(hit_tgl));

   logic unused_ok;
   assign unused_ok = m_done ^ c_done;
endmodule

// File: rtl/tmx_timer_chk.sv
module tmx_timer_chk #(
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned NUM_MATCH = 4
) (
   input logic                 bus_clk,
   input logic                 bus_rst_n,
   input logic                 req_valid,
   input logic                 req_write,
   input logic [5:0]           req_addr,
   input logic [31:0]          req_wdata,
   input logic                 irq,
   input logic [NUM_MATCH-1:0] status,
   input logic [NUM_MATCH-1:0] hit_set,
   input logic                 m_busy,
   input logic [CNT_W-1:0]     mval_q,
   input logic                 c_busy,
   input logic                 s_done,
   input logic [CNT_W-1:0]     cnt_rd
);
   logic w_any, w_match, w_count, w_stat, w_ien;
   assign w_any   = req_valid && req_write;
   assign w_match = w_any && (req_addr[5:4] == 2'b00) && (req_addr[1:0] == 2'b00)
                    && (32'(req_addr[3:2]) < NUM_MATCH);
   assign w_count = w_any && (req_addr == 6'h10);
   assign w_stat  = w_any && (req_addr == 6'h14);
   assign w_ien   = w_any && (req_addr == 6'h1C);

   AST_SET_BEATS_CLEAR: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      hit_set[0] |=> status[0]);                                            // R10
   AST_CLEAR_BY_ONE: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (w_stat && req_wdata[0] && !hit_set[0]) |=> !status[0]);              // R9
   AST_IRQ_HAS_CAUSE: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      $rose(irq) |-> ($past(hit_set[0]) || $past(w_ien)));                  // R11
   AST_MATCH_WRITE_DROP: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (w_match && m_busy) |=> $stable(mval_q));                             // R6
   AST_LOAD_BUSY_RISES: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (w_count && !c_busy) |=> c_busy);                                     // R5
   AST_SNAPSHOT_HOLD: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      !s_done |=> $stable(cnt_rd));                                         // R4
endmodule

bind tmx_timer tmx_timer_chk #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_chk (
   .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .req_valid(req_valid),
   .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
   .irq(irq), .status(status), .hit_set(hit_set), .m_busy(m_busy),
   .mval_q(mval_q), .c_busy(c_busy), .s_done(s_done), .cnt_rd(cnt_rd));

// File: tb/tb_tmx_timer.sv
module tb_tmx_timer;
   logic        bus_clk = 1'b0, tick_clk = 1'b0;
   logic        bus_rst_n = 1'b0, tick_rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [5:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, irq;
   logic [31:0] rsp_rdata;

   always #10 bus_clk  = ~bus_clk;    // 50 MHz
   always #75 tick_clk = ~tick_clk;   // slow tick

   tmx_timer dut (
      .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .tick_clk(tick_clk), .tick_rst_n(tick_rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq));

   typedef struct { bit chk; logic [31:0] exp; string tag; } exp_t;
   exp_t sbq[$];
   int   n_chk = 0, n_err = 0;

   task automatic note(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops one expectation per read response
   always @(negedge bus_clk) begin
      exp_t e;
      if (rsp_valid) begin
         if (sbq.size() == 0) note(1'b0, "R2 response without request", rsp_rdata, 32'h0);
         else begin
            e = sbq.pop_front();
            if (e.chk) note(rsp_rdata === e.exp, e.tag, rsp_rdata, e.exp);
         end
      end
   end

   // driver tasks: called at a bus negedge, return at a bus negedge
   task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge bus_clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic bus_rd(input logic [5:0] a, input bit chk, input logic [31:0] exp,
                         input string tag, output logic [31:0] d);
      exp_t e;
      e.chk = chk; e.exp = exp; e.tag = tag;
      sbq.push_back(e);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge bus_clk);
      d = rsp_rdata;
      req_valid = 1'b0;
   endtask

   task automatic expect_rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
      logic [31:0] d;
      bus_rd(a, 1'b1, exp, tag, d);
   endtask

   task automatic wait_idle(input int b, input string tag);
      logic [31:0] d;
      bit done = 1'b0;
      for (int k = 0; k < 3000; k++) begin
         bus_rd(6'h24, 1'b0, 32'h0, "", d);
         if (!d[b]) begin done = 1'b1; break; end
      end
      if (!done) note(1'b0, tag, d, 32'h0);
   endtask

   task automatic snapshot(input bit run, output logic [31:0] v);
      bus_write(6'h20, run ? 32'h3 : 32'h2);
      wait_idle(5, "R4 snapshot busy stuck");
      bus_rd(6'h10, 1'b0, 32'h0, "", v);
   endtask

   task automatic ticks(input int n);
      repeat (n) @(posedge tick_clk);
      @(negedge bus_clk);
   endtask

   initial begin
      #3000000;
      note(1'b0, "watchdog expired", 32'h0, 32'h0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [31:0] v1, v2, v;
      int highs;
      repeat (5) @(negedge bus_clk);
      bus_rst_n = 1'b1; tick_rst_n = 1'b1;
      @(negedge bus_clk);

      // R1 / R2 reset state and map
      note(irq === 1'b0, "R1 irq after reset", {31'b0, irq}, 32'h0);
      expect_rd(6'h00, 32'hFFFF_FFFF, "R1 match0 reset");
      expect_rd(6'h04, 32'hFFFF_FFFF, "R1 match1 reset");
      expect_rd(6'h08, 32'hFFFF_FFFF, "R1 match2 reset");
      expect_rd(6'h0C, 32'hFFFF_FFFF, "R1 match3 reset");
      expect_rd(6'h10, 32'h0, "R1 count reset");
      expect_rd(6'h14, 32'h0, "R1 status reset");
      expect_rd(6'h1C, 32'h0, "R1 enable reset");
      expect_rd(6'h20, 32'h0, "R1 control reset");
      expect_rd(6'h24, 32'h0, "R1 access reset");
      expect_rd(6'h18, 32'h0, "R2 unmapped offset");
      bus_write(6'h1C, 32'h0);
      note(rsp_valid === 1'b0, "R2 no response to write", {31'b0, rsp_valid}, 32'h0);

      // R5 load with busy, R4 snapshot with busy
      bus_write(6'h10, 32'h100);
      expect_rd(6'h24, 32'h10, "R5 load busy bit4");
      wait_idle(4, "R5 load busy stuck");
      bus_write(6'h20, 32'h2);
      expect_rd(6'h24, 32'h20, "R4 snapshot busy bit5");
      wait_idle(5, "R4 snapshot busy stuck");
      expect_rd(6'h10, 32'h100, "R5 loaded value via snapshot");

      // R12 second load while busy is dropped
      bus_write(6'h10, 32'h200);
      bus_write(6'h10, 32'h300);
      wait_idle(4, "R12 load busy stuck");
      snapshot(1'b0, v);
      note(v === 32'h200, "R12 load while busy dropped", v, 32'h200);

      // R3 counting while enabled, holding while disabled
      bus_write(6'h20, 32'h1);
      ticks(20);
      bus_write(6'h20, 32'h0);
      ticks(6);
      snapshot(1'b0, v1);
      note((v1 >= 32'h200 + 15) && (v1 <= 32'h200 + 25), "R3 count advanced about 20", v1, 32'h214);
      ticks(5);
      snapshot(1'b0, v2);
      note(v2 === v1, "R3 count holds when disabled", v2, v1);

      // R6 match write while busy dropped
      bus_write(6'h04, 32'hAAAA);
      bus_write(6'h04, 32'hBBBB);
      expect_rd(6'h24, 32'h1, "R6 match busy bit0");
      wait_idle(0, "R6 match busy stuck");
      expect_rd(6'h04, 32'hAAAA, "R6 match write while busy dropped");

      // R7 wrap, R8 match flags
      bus_write(6'h00, 32'h2);
      wait_idle(0, "R8 match busy stuck");
      bus_write(6'h10, 32'hFFFF_FFFC);
      wait_idle(4, "R7 load busy stuck");
      bus_write(6'h20, 32'h1);
      ticks(15);
      bus_write(6'h20, 32'h0);
      ticks(6);
      expect_rd(6'h14, 32'hD, "R8 flags for matches 0,2,3");
      snapshot(1'b0, v);
      note(v < 32'h20 && v > 32'h2, "R7 count wrapped past zero", v, 32'hB);

      // R11 interrupt gating, R9 write-one-to-clear
      note(irq === 1'b0, "R11 irq low while disabled", {31'b0, irq}, 32'h0);
      bus_write(6'h1C, 32'h1);
      note(irq === 1'b1, "R11 irq with flag0 and enable", {31'b0, irq}, 32'h1);
      bus_write(6'h14, 32'h4);
      expect_rd(6'h14, 32'h9, "R9 clear bit2 only");
      bus_write(6'h14, 32'h0);
      expect_rd(6'h14, 32'h9, "R9 zero write no effect");
      bus_write(6'h14, 32'h1);
      note(irq === 1'b0, "R11 bit3 alone does not drive irq", {31'b0, irq}, 32'h0);
      bus_write(6'h14, 32'hF);
      expect_rd(6'h14, 32'h0, "R9 0xF clears all");

      // R10 set and clear in the same cycle
      bus_write(6'h10, 32'h0);
      wait_idle(4, "R10 load busy stuck");
      bus_write(6'h00, 32'd40);
      wait_idle(0, "R10 match busy stuck");
      bus_write(6'h20, 32'h1);
      highs = 0;
      for (int k = 0; k < 700; k++) begin
         bus_write(6'h14, 32'h1);
         if (irq === 1'b1) highs++;
      end
      bus_write(6'h20, 32'h0);
      note(highs == 1, "R10 set wins over clear, irq seen once", 32'(highs), 32'h1);
      expect_rd(6'h14, 32'h0, "R9 flag cleared after storm");

      repeat (4) @(negedge bus_clk);
      note(sbq.size() == 0, "R2 every read answered", 32'(sbq.size()), 32'h0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule